// File: doc/BRIEF.md
# CCD Line-Table Timing Sequencer

This block produces the two vertical and two horizontal clock phases for a two-phase CCD sensor, plus an enable that marks when the horizontal clocks are active. One clock cycle of `clk` is one pixel time. The sequencer steps through three line tables. The first is an idle hold that waits for an external trigger. The second is an integration loop with the horizontal register clocked continuously. The third is a binning line transfer: it pulses the vertical phases twice so that two rows of charge sum into each horizontal pixel, and then reads the line out.

A rising edge on `trig_in`, which passes through a two-flop synchroniser, moves the sequencer from hold into integration. A one-cycle `integ_done` strobe ends integration. Each line is a double vertical transfer followed by a horizontal readout of `READ_PIX` pixels. After `LINES` lines the sequencer returns to hold. `bin_mode` selects the readout horizontal rate: half rate (two pixel times per sample) or full rate. The clock rails' low and mid levels appear here only as logic 0 and 1.

Top module: `ccd_line_seq`

## Requirements
- R1: A synchronous active-high reset, applied in any state, puts the block in hold on the next edge, with `v1`, `v2`, `h1`, `h2` and `h_en` all 0.
- R2: In hold all outputs stay 0. A 0-to-1 change on `trig_in` made between edges makes `h_en` go to 1 in the third cycle after it. Outputs stay 0 in the two cycles before that.
- R3: During integration, `v1` and `v2` are 0 and `h_en` is 1. `h2` is the complement of `h1`, and `h1` toggles every cycle, starting at 0 in the first integration cycle.
- R4: Integration repeats until `integ_done` is 1 at an edge. The transfer starts in the next cycle, with `h_en`, `h1` and `h2` at 0.
- R5: Each transfer is nine steps whose pulse steps last `T_EDGE` cycles and whose gap steps last `T_STEP` cycles: gap, V1 pulse, gap, V2 pulse, gap, V2 pulse, gap, V1 pulse, gap. With the defaults the pulses start 1, 32, 63 and 94 cycles after the transfer begins. `v1` and `v2` are never 1 together.
- R6: After the transfer, `h_en` is 1 for `READ_PIX` cycles and `h1` starts at 0. With `bin_mode`=1, `h1` changes every second cycle. With `bin_mode`=0, it changes every cycle. `h2` is the complement of `h1`.
- R7: After `LINES` transfer-plus-readout lines, the block returns to hold with all outputs 0.
- R8: If `trig_in` is still 1 on return to hold, with no new 0-to-1 change, the block stays in hold.
- R9: `integ_done` has no effect outside integration. A strobe during hold leaves every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one cycle per pixel time |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger; its rising edge starts integration |
| integ_done | input | 1 | Integration-complete strobe, synchronous |
| bin_mode | input | 1 | 1 selects half-rate horizontal readout |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h_en | output | 1 | Horizontal clock enable |

## Verification
The hardest situation to reach from the ports is the edge of each table: the single gap pixels between vertical pulses, the hand-off from the last gap into readout, and the second line's restart. These are only visible when the bench follows every cycle of a full frame. The stimulus triggers a frame, ends integration with one strobe, and then walks a per-line segment table against every output cycle. It does this for both readout rates. It then holds the trigger high after the frame, and pulses `integ_done` in hold, to show that neither restarts the sequence.

// File: rtl/ccd_line_seq.sv
module ccd_line_seq #(
  parameter int T_EDGE   = 30,
  parameter int T_STEP   = 1,
  parameter int READ_PIX = 16,
  parameter int LINES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic integ_done,
  input  logic bin_mode,
  output logic v1,
  output logic v2,
  output logic h1,
  output logic h2,
  output logic h_en
);
  localparam int MAXC = (T_EDGE > READ_PIX) ? ((T_EDGE > T_STEP) ? T_EDGE : T_STEP)
                                            : ((READ_PIX > T_STEP) ? READ_PIX : T_STEP);
  localparam int CW = $clog2(MAXC + 1);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [3:0] LAST_STEP = 4'd8;

  typedef enum logic [1:0] {HOLD, INTEG, XFER, READ} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [3:0]    step;
  logic [LW-1:0] line;
  logic          hph, hdiv;
  logic [2:0]    tsy;

  wire trig_rise = tsy[1] & ~tsy[2];
  wire [CW-1:0] step_last = step[0] ? CW'(T_EDGE - 1) : CW'(T_STEP - 1);
  wire h_adv = !bin_mode || hdiv;

  assign h_en = (st == INTEG) || (st == READ);
  assign h1   = h_en & hph;
  assign h2   = h_en & ~hph;
  assign v1   = (st == XFER) && (step == 4'd1 || step == 4'd7);
  assign v2   = (st == XFER) && (step == 4'd3 || step == 4'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      tsy  <= '0;
      st   <= HOLD;
      cnt  <= '0;
      step <= '0;
      line <= '0;
      hph  <= 1'b0;
      hdiv <= 1'b0;
    end else begin
      tsy <= {tsy[1:0], trig_in};
      case (st)
        HOLD: if (trig_rise) begin
          st  <= INTEG;
          hph <= 1'b0;
        end
        INTEG: begin
          hph <= ~hph;
          if (integ_done) begin
            st   <= XFER;
            step <= '0;
            cnt  <= '0;
            line <= '0;
          end
        end
        XFER: begin
          if (cnt == step_last) begin
            cnt <= '0;
            if (step == LAST_STEP) begin
              st   <= READ;
              hph  <= 1'b0;
              hdiv <= 1'b0;
            end else begin
              step <= step + 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        READ: begin
          hdiv <= ~hdiv;
          if (h_adv) hph <= ~hph;
          if (cnt == CW'(READ_PIX - 1)) begin
            cnt <= '0;
            if (line == LW'(LINES - 1)) begin
              st <= HOLD;
            end else begin
              line <= line + 1'b1;
              st   <= XFER;
              step <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= HOLD;
      endcase
    end
  end

  // R1
  reset_hold_chk: assert property (@(posedge clk) $past(rst) |-> (st == HOLD && !v1 && !v2 && !h_en));

  // R5
  phase_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(v1 && v2));

  // R3
  integ_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == INTEG) |=> (st != INTEG || h1 != $past(h1)));

  // R4
  integ_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == INTEG && integ_done) |=> (st == XFER && !h_en));

  // R8
  hold_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st == HOLD && !trig_rise) |=> (st == HOLD));

  // R6
  read_full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == READ && !bin_mode) |=> (st != READ || h1 != $past(h1)));
endmodule

// File: tb/test_ccd_line_seq.sv
`timescale 1ns/1ps
module test_ccd_line_seq;
  logic clk = 1'b0, rst = 1'b1, trig_in = 1'b0, integ_done = 1'b0, bin_mode = 1'b1;
  logic v1, v2, h1, h2, h_en;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ccd_line_seq i_ccd_line_seq (
    .clk(clk), .rst(rst), .trig_in(trig_in), .integ_done(integ_done),
    .bin_mode(bin_mode), .v1(v1), .v2(v2), .h1(h1), .h2(h2), .h_en(h_en)
  );

  // per line segments: {len[7:0], v1, v2, h_en}
  localparam logic [10:0] SEG [10] = '{
    {8'd1, 3'b000}, {8'd30, 3'b100}, {8'd1, 3'b000}, {8'd30, 3'b010}, {8'd1, 3'b000},
    {8'd30, 3'b010}, {8'd1, 3'b000}, {8'd30, 3'b100}, {8'd1, 3'b000}, {8'd16, 3'b001}};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {v1, v2, h_en, h1, h2};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b (v1 v2 h_en h1 h2)", req, act, exp);
    end
  endtask

  task automatic start_integ();
    trig_in = 1'b1;
    tick(); chk("R2", 5'b00000);
    tick(); chk("R2", 5'b00000);
    tick(); chk("R2", 5'b00101);
  endtask

  task automatic run_frame(logic bm);
    bin_mode = bm;
    for (int i = 1; i <= 6; i++) begin
      tick();
      chk("R3", {3'b001, 1'(i & 1), ~1'(i & 1)});
    end
    integ_done = 1'b1;
    tick();
    integ_done = 1'b0;
    for (int ln = 0; ln < 2; ln++)
      for (int s = 0; s < 10; s++)
        for (int j = 0; j < int'(SEG[s][10:3]); j++) begin
          logic hb;
          hb = bm ? 1'((j >> 1) & 1) : 1'(j & 1);
          if (SEG[s][0])
            chk("R6", {3'b001, hb, ~hb});
          else if (ln == 0 && s == 0)
            chk("R4", {SEG[s][2:0], 2'b00});
          else
            chk("R5", {SEG[s][2:0], 2'b00});
          tick();
        end
    chk("R7", 5'b00000);
    for (int i = 0; i < 12; i++) begin
      tick();
      chk("R8", 5'b00000);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1", 5'b00000);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2", 5'b00000);
    end
    integ_done = 1'b1;
    tick();
    integ_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R9", 5'b00000);
    end
    start_integ();
    run_frame(1'b1);
    trig_in = 1'b0;
    tick(); tick(); tick();
    start_integ();
    run_frame(1'b0);
    trig_in = 1'b0;
    tick(); tick(); tick();
    start_integ();
    tick();
    rst = 1'b1;
    tick();
    chk("R1", 5'b00000);
    rst = 1'b0;
    tick();
    chk("R1", 5'b00000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule